// File: doc/BRIEF.md
# Serial-Bus Audio Settings Decoder

This block is a write-only target on a two-wire serial bus (I2C standard mode). It runs on a fast system clock and watches the open-drain clock and data lines through synchronizers. It responds to a single fixed 7-bit address. After a matching write address it takes any number of command bytes. Each byte names its own destination through a short prefix in its top bits: master volume, one of four speaker attenuators, or input selection with input gain. No register address is sent and there is no auto-increment.

The decoded settings are held in registers and presented on plain output ports, where the analog control logic reads them. For each of the four speakers the block also presents a combined attenuation: the volume steps plus the speaker steps, counted in 1.25 dB units. A muted speaker reports a reserved all-ones value instead of that sum.

Top module: `audio_cmd_i2c`

## Requirements
- R1: After reset the outputs are: volume code 0x3F, input select 2'b11 (fourth input), gain code 2'b11 (0 dB), all four speaker codes 5'h1F, all mute flags set, and every combined attenuation 7'h7F.
- R2: A write to address 7'h44 (bus byte 0x88) is acknowledged. The block pulls SDA low from the falling SCL edge that ends the eighth bit until the falling edge that ends the ninth. It acknowledges every following command byte the same way.
- R3: An address byte that does not match, or that carries the direction bit 1, is not acknowledged. Every byte that follows it, up to the next start, is neither acknowledged nor applied.
- R4: A byte 00xxxxxx sets the volume code to its low six bits. Volume steps equal 8 times bits 5..3 plus bits 2..0.
- R5: A byte 1ccxxxxx writes its low five bits to the speaker code at index cc. Index 0 is left-front, 1 is right-front, 2 is left-rear and 3 is right-rear. Speaker i occupies bits 5i+4..5i of the speaker code port.
- R6: A byte 010ggxss sets the gain code to gg and the input select to ss. Input select 00..11 means inputs 1..4. Gain code 00, 01, 10, 11 means +11.25, +7.5, +3.75 and 0 dB.
- R7: A byte with prefix 011 is acknowledged and changes no output.
- R8: Several command bytes in one transaction are each applied in order, so a later byte to the same destination wins.
- R9: A setting changes only on the falling SCL edge that ends the acknowledge of a complete byte. A stop or start inside a byte discards that byte.
- R10: A speaker's mute flag is set exactly when its code is 5'h1F. The combined attenuation of speaker i, on bits 7i+6..7i, is then 7'h7F; otherwise it is the volume code plus the speaker code, as a 7-bit number.
- R11: A repeated start, even in the middle of a byte, restarts address reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 20 times the bus clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | When high, the pad pulls the data line low |
| vol_code_o | output | 6 | Master volume code, in 1.25 dB steps of attenuation |
| spk_code_o | output | 20 | Four 5-bit speaker codes: LF, RF, LR, RR from bit 0 up |
| spk_mute_o | output | 4 | Per-speaker mute flags |
| in_sel_o | output | 2 | Selected stereo input |
| in_gain_o | output | 2 | Input gain code |
| ch_atten_o | output | 28 | Four 7-bit combined attenuations, in 1.25 dB units |

## Verification
The hardest situations to reach from the ports are a transaction that is cut off partway through a byte and one that restarts without a stop. In both, a half-shifted byte must leave every setting untouched. The stimulus reaches them with directed transfers that break off after a few bits, either with a stop or with a fresh start that carries a new address and command. Random transactions then mix all prefixes with wrong and read addresses. After every transaction the bench compares all outputs against a model that applies only the acknowledged bytes.

// File: rtl/audio_cmd_i2c.sv
module audio_cmd_i2c #(
  parameter logic [6:0] DEV_ADDR = 7'h44,
  parameter int         NCH      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic [5:0]        vol_code_o,
  output logic [NCH*5-1:0]  spk_code_o,
  output logic [NCH-1:0]    spk_mute_o,
  output logic [1:0]        in_sel_o,
  output logic [1:0]        in_gain_o,
  output logic [NCH*7-1:0]  ch_atten_o
);
  localparam logic [7:0] ADDR_WR = {DEV_ADDR, 1'b0};
  localparam logic [4:0] MUTE_CODE = 5'h1F;

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_DATA} st_t;

  logic [2:0] scl_p, sda_p;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_p <= 3'b111;
      sda_p <= 3'b111;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end

  wire scl_s = scl_p[1];
  wire scl_d = scl_p[2];
  wire sda_s = sda_p[1];
  wire sda_d = sda_p[2];
  wire start_det = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_det  = scl_s & scl_d & ~sda_d & sda_s;
  wire scl_rise  = scl_s & ~scl_d;
  wire scl_fall  = ~scl_s & scl_d;

  st_t        st;
  logic [3:0] bcnt;
  logic [7:0] shreg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st       <= ST_IDLE;
      bcnt     <= '0;
      shreg    <= '0;
      sda_oe_o <= 1'b0;
    end else if (start_det) begin
      st       <= ST_ADDR;
      bcnt     <= '0;
      sda_oe_o <= 1'b0;
    end else if (stop_det) begin
      st       <= ST_IDLE;
      bcnt     <= '0;
      sda_oe_o <= 1'b0;
    end else if (st != ST_IDLE) begin
      if (scl_rise && bcnt < 4'd8) begin
        shreg <= {shreg[6:0], sda_s};
        bcnt  <= bcnt + 4'd1;
      end else if (scl_fall && bcnt == 4'd8) begin
        if (st == ST_DATA || shreg == ADDR_WR) begin
          sda_oe_o <= 1'b1;
          bcnt     <= 4'd9;
        end else begin
          st <= ST_IDLE;
        end
      end else if (scl_fall && bcnt == 4'd9) begin
        sda_oe_o <= 1'b0;
        bcnt     <= '0;
        st       <= ST_DATA;
      end
    end

  wire commit = (st == ST_DATA) && scl_fall && (bcnt == 4'd9);

  logic [4:0] spk [NCH];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      vol_code_o <= 6'h3F;
      in_sel_o   <= 2'b11;
      in_gain_o  <= 2'b11;
      for (int i = 0; i < NCH; i++) spk[i] <= MUTE_CODE;
    end else if (commit) begin
      if (shreg[7:6] == 2'b00)
        vol_code_o <= shreg[5:0];
      else if (shreg[7:5] == 3'b010) begin
        in_gain_o <= shreg[4:3];
        in_sel_o  <= shreg[1:0];
      end else if (shreg[7])
        spk[shreg[6:5]] <= shreg[4:0];
    end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    wire [6:0] sum = {1'b0, vol_code_o} + {2'b00, spk[g]};
    assign spk_code_o[g*5 +: 5] = spk[g];
    assign spk_mute_o[g]        = (spk[g] == MUTE_CODE);
    assign ch_atten_o[g*7 +: 7] = spk_mute_o[g] ? 7'h7F : sum;
  end

  // R2
  ack_on_low_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> !scl_s);

  // R3
  idle_never_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_oe_o);

  // R11
  start_restarts_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (st == ST_ADDR && !sda_oe_o && bcnt == 4'd0));

  // R9
  vol_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(vol_code_o));

  // R9
  spk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(spk_code_o) && $stable(in_sel_o) && $stable(in_gain_o));

  // R2
  ack_held_high_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe_o && scl_s && !start_det && !stop_det) |=> sda_oe_o);
endmodule

// File: tb/audio_cmd_i2c_bench.sv
module audio_cmd_i2c_bench;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic        sda_oe;
  logic [5:0]  vol;
  logic [19:0] spk_code;
  logic [3:0]  spk_mute;
  logic [1:0]  sel, gain;
  logic [27:0] atten;
  wire sda_bus = sda_m & ~sda_oe;

  always #10 clk = ~clk;

  audio_cmd_i2c u_audio_cmd_i2c (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .vol_code_o(vol), .spk_code_o(spk_code),
    .spk_mute_o(spk_mute), .in_sel_o(sel), .in_gain_o(gain),
    .ch_atten_o(atten));

  int n_chk = 0;
  int n_fail = 0;
  logic [5:0] e_vol = 6'h3F;
  logic [4:0] e_spk [4] = '{5'h1F, 5'h1F, 5'h1F, 5'h1F};
  logic [1:0] e_sel = 2'b11;
  logic [1:0] e_gain = 2'b11;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic void model_apply(logic [7:0] b);
    if (b[7:6] == 2'b00) e_vol = b[5:0];
    else if (b[7:5] == 3'b010) begin e_gain = b[4:3]; e_sel = b[1:0]; end
    else if (b[7]) e_spk[b[6:5]] = b[4:0];
  endfunction

  task automatic check_all(string req);
    @(negedge clk);
    chk({req, " vol"}, vol, e_vol);
    chk({req, " sel"}, sel, e_sel);
    chk({req, " gain"}, gain, e_gain);
    for (int i = 0; i < 4; i++) begin
      logic mu = (e_spk[i] == 5'h1F);
      chk({req, " spk R5"}, spk_code[i*5 +: 5], e_spk[i]);
      chk({req, " mute R10"}, spk_mute[i], mu);
      chk({req, " atten R10"}, atten[i*7 +: 7],
          mu ? 7'h7F : 7'({1'b0, e_vol} + {2'b00, e_spk[i]}));
    end
  endtask

  task automatic qw(); repeat (Q) @(posedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); sda_m = 1'b1; qw(); qw();
  endtask

  task automatic send_bit(logic b);
    sda_m = b; qw(); scl_m = 1'b1; qw(); qw(); scl_m = 1'b0; qw();
  endtask

  task automatic send_byte(logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw();
    acked = ~sda_bus;
    qw(); scl_m = 1'b0; qw();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic a;
    int unused;
    unused = $urandom(32'd2718);
    repeat (5) @(posedge clk);
    rst_n = 1'b1;
    qw();
    check_all("R1 reset");

    // R2 R4 R5 R6 R8: command examples in one transaction
    bus_start();
    send_byte(8'h88, a); chk("R2 addr ack", a, 1);
    send_byte(8'h1E, a); chk("R2 data ack", a, 1); model_apply(8'h1E);
    send_byte(8'hB8, a); model_apply(8'hB8);
    send_byte(8'hFF, a); model_apply(8'hFF);
    send_byte(8'h45, a); model_apply(8'h45);
    send_byte(8'h81, a); model_apply(8'h81);
    send_byte(8'h82, a); model_apply(8'h82);
    bus_stop();
    check_all("R4 R5 R6 R8");
    chk("R4 vol -37.5dB", vol, 6'd30);
    chk("R6 sel input2", sel, 2'b01);
    chk("R5 rf -30dB", spk_code[9:5], 5'h18);

    // R7: undefined prefix acknowledged and dropped
    bus_start();
    send_byte(8'h88, a);
    send_byte(8'h6A, a); chk("R7 ack", a, 1);
    bus_stop();
    check_all("R7 no change");

    // R3: wrong address, then read direction
    bus_start();
    send_byte(8'h8A, a); chk("R3 wrong addr nack", a, 0);
    send_byte(8'h00, a); chk("R3 data nack", a, 0);
    bus_stop();
    bus_start();
    send_byte(8'h89, a); chk("R3 read nack", a, 0);
    send_byte(8'h40, a); chk("R3 data nack", a, 0);
    bus_stop();
    check_all("R3 ignored");

    // R9: stop in the middle of a byte
    bus_start();
    send_byte(8'h88, a);
    for (int i = 0; i < 5; i++) send_bit(1'b0);
    bus_stop();
    check_all("R9 partial dropped");

    // R11: repeated start in the middle of a byte
    bus_start();
    send_byte(8'h88, a);
    send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
    bus_start();
    send_byte(8'h88, a); chk("R11 readdress ack", a, 1);
    send_byte(8'h05, a); model_apply(8'h05);
    bus_stop();
    check_all("R11 restart");
    chk("R11 vol", vol, 6'd5);

    // R8 R10: random transactions
    for (int t = 0; t < 60; t++) begin
      logic [7:0] ad;
      logic good;
      int nb;
      ad = ($urandom % 6 == 0) ? 8'($urandom) : 8'h88;
      good = (ad == 8'h88);
      nb = 1 + ($urandom % 3);
      bus_start();
      send_byte(ad, a); chk("R2 R3 addr ack", a, good);
      for (int k = 0; k < nb; k++) begin
        logic [7:0] b;
        b = 8'($urandom);
        if ($urandom % 4 == 0) b[4:0] = 5'h1F;
        send_byte(b, a); chk("R2 R3 data ack", a, good);
        if (good) model_apply(b);
      end
      bus_stop();
      check_all("R8 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule